// File: doc/BRIEF.md
# Saturation-Sealing Trip Supervisor for Bus Differential Protection

This block watches the trajectory of a bus differential element in the plane of differential magnitude against restraint magnitude. When an external fault occurs, the CTs first reproduce the current faithfully. The restraint magnitude climbs well past the upper breakpoint, but the differential magnitude stays below the lower percent slope. The block recognises this pattern and sets a saturation flag. A small state machine then keeps that flag set after the transient condition has gone, until the trajectory has been quiet for a programmed number of evaluations.

The flag decides how the trip is formed. For low differential currents, a trip always needs two confirmations: the differential element and the phase-directional element. For high differential currents, the differential element can trip alone while no saturation is flagged. Once saturation is flagged, the directional element must also agree. Every input is sampled on an evaluation strobe, and the state, the flag and the trip change only on strobe cycles.

Top module: `sat_trip_supervisor`

## Requirements
- R1: After synchronous reset, `state` is 0 (quiet), `sat_flag` is 0 and `trip` is 0.
- R2: `state`, `sat_flag` and `trip` change only on a clock edge where `strobe` is 1.
- R3: From quiet (code 0), the block moves to external-fault (code 1) on a strobe where both of these hold:
  - `rest_mag > hi_bpnt`, strictly;
  - `diff_mag * 2^SW < rest_mag * lo_slope`, strictly. Here `lo_slope` is a fraction with SW fraction bits.
- R4: In external-fault, a strobe with `dif_lo_op` or `dif_hi_op` set moves the block to saturated (code 2). This takes priority over the dwell count.
- R5: In saturated, `ext_dwell`-style counting applies with `sat_dwell`: the block returns to external-fault (never directly to quiet) on the `sat_dwell`-th consecutive strobe with both operate flags clear. A limit of 0 acts as 1.
- R6: In external-fault, the block returns to quiet on the `ext_dwell`-th consecutive strobe whose differential lies below the slope line of R3. A limit of 0 acts as 1.
- R7: In external-fault, a strobe with no operate flag and the differential on or above the slope line restarts the quiet count, and the state stays external-fault.
- R8: `sat_flag` is 1 exactly when `state` is 1 or 2. Code 3 is never produced.
- R9: On each strobe, `trip` is registered as `(dif_lo_op & dir_ok) | (dif_hi_op & (~S | dir_ok))`, where S is the saturation flag resulting from that same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Evaluation strobe, one cycle per evaluation |
| diff_mag | input | W | Differential current magnitude |
| rest_mag | input | W | Restraint current magnitude |
| hi_bpnt | input | W | Upper breakpoint setting |
| lo_slope | input | SW | Lower slope, fraction with SW fraction bits |
| ext_dwell | input | CW | Strobes below slope needed to leave external-fault |
| sat_dwell | input | CW | Quiet strobes needed to leave saturated |
| dif_lo_op | input | 1 | Low-region differential operate flag |
| dif_hi_op | input | 1 | High-region differential operate flag |
| dir_ok | input | 1 | Directional element declares internal fault |
| sat_flag | output | 1 | Saturation flag |
| trip | output | 1 | Registered trip decision |
| state | output | 2 | Supervisor state: 0 quiet, 1 external-fault, 2 saturated |

## Verification
The hardest situations to reach from the ports are the dwell runs that are broken one strobe before they complete. They must restart the count without changing state, and the return from saturated must go to external-fault rather than to quiet. Directed sequences first lead the block through a full external-fault episode. They then break each run at its last strobe and complete it again, with a different limit in force each time.

A long pseudo-random sweep then runs over small magnitudes around the breakpoint and the slope line. It uses sparse operate and directional flags, so that every state meets every flag combination many times. A bench-side model, built from the requirements, predicts the state, the flag and the trip after each strobe.

// File: rtl/sat_trip_supervisor.sv
module sat_trip_supervisor #(
  parameter int W  = 16,
  parameter int SW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [W-1:0]  diff_mag,
  input  logic [W-1:0]  rest_mag,
  input  logic [W-1:0]  hi_bpnt,
  input  logic [SW-1:0] lo_slope,
  input  logic [CW-1:0] ext_dwell,
  input  logic [CW-1:0] sat_dwell,
  input  logic          dif_lo_op,
  input  logic          dif_hi_op,
  input  logic          dir_ok,
  output logic          sat_flag,
  output logic          trip,
  output logic [1:0]    state
);

  localparam int PW = W + SW;

  typedef enum logic [1:0] {
    S_QUIET = 2'd0,
    S_EXT   = 2'd1,
    S_SAT   = 2'd2
  } sup_state_t;

  sup_state_t cur_q, cur_nx;
  logic [CW-1:0] run_q, run_nx;

  logic [PW-1:0] slope_line;
  logic [PW-1:0] diff_scaled;
  logic          below_line;
  logic          rest_high;
  logic          in_char;
  logic [CW:0]   run_plus;
  logic          ext_done;
  logic          sat_done;
  logic [CW-1:0] run_step;
  logic          sat_nx;

  assign slope_line  = PW'(rest_mag) * PW'(lo_slope);
  assign diff_scaled = {diff_mag, {SW{1'b0}}};
  assign below_line  = diff_scaled < slope_line;
  assign rest_high   = rest_mag > hi_bpnt;
  assign in_char     = dif_lo_op | dif_hi_op;

  assign run_plus = {1'b0, run_q} + 1'b1;
  assign ext_done = run_plus >= {1'b0, ext_dwell};
  assign sat_done = run_plus >= {1'b0, sat_dwell};
  assign run_step = (&run_q) ? run_q : run_q + 1'b1;

  always_comb begin
    cur_nx = cur_q;
    run_nx = '0;
    case (cur_q)
      S_QUIET: begin
        if (rest_high && below_line) cur_nx = S_EXT;
      end
      S_EXT: begin
        if (in_char) begin
          cur_nx = S_SAT;
        end else if (below_line) begin
          if (ext_done) cur_nx = S_QUIET;
          else          run_nx = run_step;
        end
      end
      S_SAT: begin
        if (!in_char) begin
          if (sat_done) cur_nx = S_EXT;
          else          run_nx = run_step;
        end
      end
      default: cur_nx = S_QUIET;
    endcase
  end

  assign sat_nx = (cur_nx != S_QUIET);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= S_QUIET;
      run_q <= '0;
      trip  <= 1'b0;
    end else if (strobe) begin
      cur_q <= cur_nx;
      run_q <= run_nx;
      trip  <= (dif_lo_op & dir_ok) | (dif_hi_op & (~sat_nx | dir_ok));
    end
  end

  assign state    = cur_q;
  assign sat_flag = (cur_q != S_QUIET);

endmodule

// File: rtl/sat_trip_supervisor_chk.sv
module sat_trip_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       strobe,
  input logic       dif_lo_op,
  input logic       dif_hi_op,
  input logic       dir_ok,
  input logic       sat_flag,
  input logic       trip,
  input logic [1:0] state
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (state == 2'd0 && !sat_flag && !trip));

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(state) && $stable(trip) && $stable(sat_flag)));

  a_r3_quiet_never_to_sat: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0) |=> (state != 2'd2));

  a_r5_sat_exits_to_ext: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2) |=> (state != 2'd0));

  a_r4_ext_enters_sat: assert property (@(posedge clk) disable iff (rst)
    (strobe && state == 2'd1 && (dif_lo_op || dif_hi_op)) |=> (state == 2'd2));

  a_r8_no_code3: assert property (@(posedge clk) disable iff (rst)
    state != 2'd3);

  a_r9_high_with_dir_trips: assert property (@(posedge clk) disable iff (rst)
    (strobe && dif_hi_op && dir_ok) |=> trip);

  a_r9_no_flag_no_trip: assert property (@(posedge clk) disable iff (rst)
    (strobe && !dif_hi_op && !(dif_lo_op && dir_ok)) |=> !trip);

endmodule

bind sat_trip_supervisor sat_trip_supervisor_chk u_chk (
  .clk(clk), .rst(rst), .strobe(strobe),
  .dif_lo_op(dif_lo_op), .dif_hi_op(dif_hi_op), .dir_ok(dir_ok),
  .sat_flag(sat_flag), .trip(trip), .state(state)
);

// File: tb/sat_trip_supervisor_tb.sv
module sat_trip_supervisor_tb;
  localparam int W = 16, SW = 8, CW = 8;

  logic clk = 0;
  logic rst, strobe;
  logic [W-1:0] diff_mag, rest_mag, hi_bpnt;
  logic [SW-1:0] lo_slope;
  logic [CW-1:0] ext_dwell, sat_dwell;
  logic dif_lo_op, dif_hi_op, dir_ok;
  logic sat_flag, trip;
  logic [1:0] state;

  int checks = 0, errors = 0;
  int m_state = 0, m_cnt = 0, m_trip = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sat_trip_supervisor #(.W(W), .SW(SW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .strobe(strobe),
    .diff_mag(diff_mag), .rest_mag(rest_mag), .hi_bpnt(hi_bpnt),
    .lo_slope(lo_slope), .ext_dwell(ext_dwell), .sat_dwell(sat_dwell),
    .dif_lo_op(dif_lo_op), .dif_hi_op(dif_hi_op), .dir_ok(dir_ok),
    .sat_flag(sat_flag), .trip(trip), .state(state)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " state"}, int'(state), m_state);
    check({req, " R8 sat_flag"}, int'(sat_flag), (m_state != 0) ? 1 : 0);
    check({req, " R9 trip"}, int'(trip), m_trip);
  endtask

  task automatic model(int d, int r, bit lo, bit hi, bit dr);
    int lim_e, lim_s;
    bit below;
    bit inc;
    below = (d * 256) < (r * int'(lo_slope));
    inc = lo | hi;
    lim_e = int'(ext_dwell);
    lim_s = int'(sat_dwell);
    case (m_state)
      0: begin
        m_cnt = 0;
        if (r > int'(hi_bpnt) && below) m_state = 1;
      end
      1: begin
        if (inc) begin
          m_state = 2;
          m_cnt = 0;
        end else if (below) begin
          if (m_cnt + 1 >= lim_e) begin
            m_state = 0;
            m_cnt = 0;
          end else begin
            m_cnt++;
          end
        end else begin
          m_cnt = 0;
        end
      end
      default: begin
        if (!inc) begin
          if (m_cnt + 1 >= lim_s) begin
            m_state = 1;
            m_cnt = 0;
          end else begin
            m_cnt++;
          end
        end else begin
          m_cnt = 0;
        end
      end
    endcase
    m_trip = int'((lo & dr) | (hi & ((m_state == 0) | dr)));
  endtask

  task automatic step(int d, int r, bit lo, bit hi, bit dr, string req);
    @(negedge clk);
    diff_mag = W'(d);
    rest_mag = W'(r);
    dif_lo_op = lo;
    dif_hi_op = hi;
    dir_ok = dr;
    strobe = 1;
    model(d, r, lo, hi, dr);
    @(negedge clk);
    strobe = 0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst = 1;
    strobe = 0;
    diff_mag = 0;
    rest_mag = 0;
    hi_bpnt = 100;
    lo_slope = 64;
    ext_dwell = 3;
    sat_dwell = 2;
    dif_lo_op = 0;
    dif_hi_op = 0;
    dir_ok = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 state", int'(state), 0);
    check("R1 sat", int'(sat_flag), 0);
    check("R1 trip", int'(trip), 0);

    // R3 boundaries: rest equal to breakpoint, differential on the line.
    step(10, 100, 0, 0, 0, "R3 rest==bpnt");
    step(50, 200, 0, 0, 0, "R3 diff on line");
    step(49, 200, 0, 0, 0, "R3 below line");
    check("R3 entered ext", int'(state), 1);

    // R2: no strobe, inputs toggle, outputs hold.
    @(negedge clk);
    dif_hi_op = 1;
    diff_mag = 0;
    rest_mag = 500;
    repeat (3) @(negedge clk);
    check("R2 state hold", int'(state), 1);
    check("R2 trip hold", int'(trip), 0);

    // R6/R7: break the quiet run at its last strobe, then complete it.
    step(5, 200, 0, 0, 0, "R6 run1");
    step(5, 200, 0, 0, 0, "R6 run2");
    step(90, 200, 0, 0, 0, "R7 restart");
    check("R7 still ext", int'(state), 1);
    step(5, 200, 0, 0, 0, "R6 a");
    step(5, 200, 0, 0, 0, "R6 b");
    step(5, 200, 0, 0, 0, "R6 c");
    check("R6 back to quiet", int'(state), 0);

    // R4/R5/R9: saturation entry, trip gated by direction.
    step(5, 200, 0, 0, 0, "R3 re-enter");
    step(150, 200, 0, 1, 0, "R4 R9 hi without dir blocked");
    check("R4 sat", int'(state), 2);
    check("R9 blocked", int'(trip), 0);
    step(150, 200, 0, 1, 1, "R9 hi with dir");
    step(20, 200, 1, 0, 0, "R9 lo without dir");
    step(5, 200, 0, 0, 0, "R5 q1");
    step(5, 200, 1, 0, 1, "R5 restart");
    step(5, 200, 0, 0, 0, "R5 q1b");
    step(5, 200, 0, 0, 0, "R5 q2");
    check("R5 to ext not quiet", int'(state), 1);

    // R5/R6 with limit 0 acting as 1.
    ext_dwell = 0;
    sat_dwell = 0;
    step(5, 200, 1, 0, 0, "R4 again");
    step(5, 200, 0, 0, 0, "R5 lim0");
    check("R5 lim0 ext", int'(state), 1);
    step(5, 200, 0, 0, 0, "R6 lim0");
    check("R6 lim0 quiet", int'(state), 0);
    step(150, 50, 0, 1, 0, "R9 quiet hi alone trips");
    check("R9 quiet trip", int'(trip), 1);

    // Near-exhaustive sweep around the breakpoint and slope line.
    hi_bpnt = 100;
    lo_slope = 96;
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      int d, r;
      bit lo, hi, dr;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ext_dwell = CW'((i / 500) % 4);
      sat_dwell = CW'((i / 700) % 4);
      r = 60 + int'(lf[7:0]);
      d = int'(lf[15:9]);
      lo = (lf[3:1] == 3'd0);
      hi = (lf[6:4] == 3'd0);
      dr = lf[8] ^ lf[2];
      step(d, r, lo, hi, dr, "R3-sweep R9");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule